// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a purely combinational 32-bit integer arithmetic and logic unit for a RISC-V style execute stage. It takes two operands, the three-bit `funct3` field of the instruction and instruction bit 30. It returns one result word and a four-bit condition bundle. It performs addition, subtraction, XOR, OR and AND. One ripple-carry chain serves both addition and subtraction. For subtraction the second operand is inverted and the carry-in is forced to one, so the chain computes A + ~B + 1.

The condition bundle is always taken from the adder/subtractor output, even when a logical operation drives the result. A downstream stage can therefore read the flags of A±B for every instruction. The order is {zero, carry, negative, overflow}, from bit 3 down to bit 0.

Top module: `int_alu`

## Requirements
- R1: When `funct3[2]` is 0 and `alt_op` is 0, `result` equals (`op_a` + `op_b`) mod 2^32. The values of `funct3[1:0]` do not affect this.
- R2: When `funct3[2]` is 0 and `alt_op` is 1, `result` equals (`op_a` − `op_b`) mod 2^32, computed as `op_a` + ~`op_b` + 1.
- R3: When `funct3` is 3'b100, `result` equals `op_a` XOR `op_b`, whatever the value of `alt_op`.
- R4: When `funct3` is 3'b110, `result` equals `op_a` OR `op_b`.
- R5: When `funct3` is 3'b111, `result` equals `op_a` AND `op_b`.
- R6: When `funct3` is 3'b101, `result` is all zeros.
- R7: `flags[3]` (zero) is 1 exactly when the 32-bit adder/subtractor output is zero.
- R8: `flags[2]` (carry) is the carry out of bit 31 of the adder/subtractor. For subtraction this means it is 1 when `op_a` >= `op_b` unsigned, i.e. no borrow occurs.
- R9: `flags[1]` (negative) equals bit 31 of the adder/subtractor output.
- R10: `flags[0]` (overflow) reports signed overflow. For an add it is set when both operands have the same sign and the sum's sign differs. For a subtract it is set when the operand signs differ and the difference's sign differs from that of `op_a`.
- R11: For logical operations (`funct3[2]` = 1), `flags` still reflects `op_a` ± `op_b`, with the operation selected by `alt_op`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| funct3 | input | 3 | Instruction funct3 field; bit 2 selects logical operations |
| alt_op | input | 1 | Instruction bit 30; 1 selects subtraction |
| result | output | 32 | Operation result |
| flags | output | 4 | {zero, carry, negative, overflow} from the arithmetic path |

## Verification
For arithmetic operations, the bound checker verifies on every input change that the zero and negative flags match the result. It also checks that an add reports carry exactly when the sum wraps below `op_a`, and that overflow never appears for operand sign pairs that cannot overflow. Two more checks confirm that the undefined logical code yields zero and that XOR matches its operands. Exact subtraction carry, the flags under logical operations, and the boundary values tell an overflow apart from a plain wrap. Only the bench's directed corners, such as the most positive value plus one, zero minus one and a value minus itself, together with its randomized comparison against a reference model, can show these.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [2:0]      funct3,
  input  logic            alt_op,
  output logic [XLEN-1:0] result,
  output logic [3:0]      flags
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;
  logic [XLEN:0]   cy;

  assign b_eff = op_b ^ {XLEN{alt_op}};
  assign cy[0] = alt_op;

  for (genvar i = 0; i < XLEN; i++) begin : g_rca
    assign sum[i]  = op_a[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1] = (op_a[i] & b_eff[i]) | (cy[i] & (op_a[i] ^ b_eff[i]));
  end

  always_comb begin
    case (funct3)
      3'b100:  result = op_a ^ op_b;
      3'b110:  result = op_a | op_b;
      3'b111:  result = op_a & op_b;
      3'b101:  result = '0;
      default: result = sum;
    endcase
  end

  assign flags[3] = ~(|sum);
  assign flags[2] = cy[XLEN];
  assign flags[1] = sum[MSB];
  assign flags[0] = (op_a[MSB] ~^ b_eff[MSB]) & (sum[MSB] ^ op_a[MSB]);
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [2:0]      funct3,
  input logic            alt_op,
  input logic [XLEN-1:0] result,
  input logic [3:0]      flags
);
  always_comb begin
    if (!funct3[2]) begin
      a_r7_zero: assert (flags[3] == (result == '0));
      a_r9_negative: assert (flags[1] == result[XLEN-1]);
      if (!alt_op) begin
        a_r8_add_carry: assert (flags[2] == (result < op_a));
        if (op_a[XLEN-1] != op_b[XLEN-1]) a_r10_add_no_overflow: assert (!flags[0]);
      end else begin
        if (op_a[XLEN-1] == op_b[XLEN-1]) a_r10_sub_no_overflow: assert (!flags[0]);
      end
    end
    if (funct3 == 3'b101) a_r6_undefined_zero: assert (result == '0);
    if (funct3 == 3'b100) a_r3_xor: assert ((result ^ op_b) == op_a);
  end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/int_alu_test.sv
module int_alu_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] op_a, op_b, result;
  logic [2:0]  funct3;
  logic        alt_op;
  logic [3:0]  flags;
  int compared = 0, mismatched = 0;

  int_alu uut (.op_a(op_a), .op_b(op_b), .funct3(funct3), .alt_op(alt_op),
               .result(result), .flags(flags));

  function automatic logic [32:0] ref_arith(input logic [31:0] a, input logic [31:0] b, input logic s);
    return s ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
  endfunction

  function automatic logic [31:0] ref_result(input logic [31:0] a, input logic [31:0] b,
                                             input logic [2:0] f, input logic s);
    logic [32:0] t;
    t = ref_arith(a, b, s);
    case (f)
      3'b100: return a ^ b;
      3'b110: return a | b;
      3'b111: return a & b;
      3'b101: return 32'd0;
      default: return t[31:0];
    endcase
  endfunction

  function automatic logic [3:0] ref_flags(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [32:0] t;
    logic v;
    t = ref_arith(a, b, s);
    if (!s) v = (a[31] == b[31]) && (t[31] != a[31]);
    else    v = (a[31] != b[31]) && (t[31] != a[31]);
    return {t[31:0] == 32'd0, t[32], t[31], v};
  endfunction

  function automatic string res_tag(input logic [2:0] f, input logic s);
    case (f)
      3'b100: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      3'b101: return "R6";
      default: return s ? "R2" : "R1";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h f3=%b alt=%b)",
               tag, act, exp, op_a, op_b, funct3, alt_op);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f, input logic s);
    logic [3:0] ef;
    @(posedge clk);
    op_a = a; op_b = b; funct3 = f; alt_op = s;
    @(negedge clk);
    ef = ref_flags(a, b, s);
    cmp(res_tag(f, s), result, ref_result(a, b, f, s));
    cmp(f[2] ? "R11" : "R7", {31'd0, flags[3]}, {31'd0, ef[3]});
    cmp(f[2] ? "R11" : "R8", {31'd0, flags[2]}, {31'd0, ef[2]});
    cmp(f[2] ? "R11" : "R9", {31'd0, flags[1]}, {31'd0, ef[1]});
    cmp(f[2] ? "R11" : "R10", {31'd0, flags[0]}, {31'd0, ef[0]});
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [2:0] codes [5];
    codes = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b101};
    op_a = '0; op_b = '0; funct3 = '0; alt_op = 1'b0;
    @(negedge clk);
    cmp("R7 idle", {28'd0, flags}, 32'h8);
    cmp("R1 idle", result, 32'd0);
    // R10 overflow corners
    apply(32'h7FFF_FFFF, 32'h1, 3'b000, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 3'b000, 1'b0);
    apply(32'h8000_0000, 32'h1, 3'b000, 1'b1);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b000, 1'b1);
    // R8 carry / borrow corners, R7 zero
    apply(32'hFFFF_FFFF, 32'h1, 3'b000, 1'b0);
    apply(32'h0, 32'h1, 3'b000, 1'b1);
    apply(32'h1234_5678, 32'h1234_5678, 3'b000, 1'b1);
    apply(32'h0, 32'h0, 3'b000, 1'b1);
    // R1 upper funct3 bit alone selects the unit
    apply(32'hDEAD_BEEF, 32'h0101_0101, 3'b001, 1'b0);
    apply(32'hDEAD_BEEF, 32'h0101_0101, 3'b011, 1'b1);
    // R3 R4 R5 R6 R11 logical with flags of arithmetic path
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b100, 1'b1);
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b110, 1'b0);
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b111, 1'b1);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b101, 1'b0);
    apply(32'h5555_5555, 32'h5555_5555, 3'b100, 1'b1);
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if ((i % 7) == 0) b = a;
      if ((i % 11) == 0) a = {a[31], {31{~a[31]}}};
      apply(a, b, (i % 9 == 0) ? 3'($urandom()) : codes[$urandom() % 5], 1'($urandom()));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule